// File: doc/BRIEF.md
# Address and Data Line Memory Self-Test Engine

This block is a built-in self-test sequencer that drives a single-port synchronous RAM. A `start` request runs three structural tests back to back. The first looks for address lines that are stuck or that alias onto each other. The second walks a single cleared bit through every bit position of every word. The third loads each location with its own address and reads the whole array back.

The RAM port has an address, write data, a write enable and read data. Read data returns one cycle after the address is presented. The engine lines up each comparison with its read by holding the expected word for that one cycle. The first mismatch is captured: its address, the expected word and the word actually read. The run still goes on to the end, and the result is shown on `done` and `pass`.

Top module: `lpb_top`

## Requirements
- R1: After reset, `done`, `pass` and `mem_we` are 0 and the three capture outputs are 0. While the engine is idle or finished, `mem_we` stays 0.
- R2: The address test runs first. It writes all ones to every location in ascending order and then writes all zeros to address 0. It then reads addresses `1<<i` for i = 0 up to AW-1 and expects all ones each time. An address line stuck at 0 therefore fails at address `1<<i`, with expected all ones and read 0.
- R3: The data test runs next. It first refills every location with all ones. Then, for each address in ascending order and each bit b from 0 upward, it writes all ones with bit b cleared, reads that word back expecting the same value, and restores the word to all ones. A bit stuck at 1 fails at the first address, at bit b, with expected `~(1<<b)` and read all ones.
- R4: The self-address test runs last. It writes every location with its own address, zero-extended or truncated to DW bits, in ascending order. It then reads every location in ascending order and compares the data with that value. This write-and-read pass runs NPASS times. After a clean run, location a holds the low DW bits of a.
- R5: The first mismatch latches `fail_addr`, `fail_exp` and `fail_got`. Later mismatches do not change them, and the run still continues until `done`.
- R6: Take the clock edge that accepts `start`. `done` rises exactly 2^AW·(3·DW + 2 + 2·NPASS) + AW + 2 edges after it.
- R7: `pass` can be 1 only while `done` is 1, and it is 1 only if no mismatch was seen. `done` holds until a new `start`. A `start` during a run is ignored and does not change the run's length.
- R8: A `start` accepted while idle or finished clears the capture outputs and `pass` before the new run begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Run request, accepted while idle or finished |
| done | output | 1 | The run has finished |
| pass | output | 1 | The finished run saw no mismatch |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | DW | RAM read data, valid one cycle after the address |
| fail_addr | output | AW | Address of the first mismatch |
| fail_exp | output | DW | Expected word at the first mismatch |
| fail_got | output | DW | Word read at the first mismatch |

## Verification
Some properties are checked by assertions on every cycle. `pass` appears only together with `done` and never after a mismatch. `done` holds until a restart. The latched failure record stays frozen once set. The RAM is never written while the engine is quiet. The bench's scenarios cover what the assertions cannot. Each fault injected into the bench's RAM model must produce the first-failure record that the test order predicts. The run must take exactly the expected number of cycles even when `start` is poked mid-run. After a clean run, the array must hold the self-address pattern.

// File: rtl/lpb_pkg.sv
package lpb_pkg;
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_FILL_A,
    PH_ABASE,
    PH_APROBE,
    PH_FILL_D,
    PH_DWALK,
    PH_SWR,
    PH_SRD,
    PH_DRAIN,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/lpb_seq.sv
module lpb_seq
  import lpb_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int NPASS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output phase_t        phase,
  output logic          busy,
  output logic          start_acc,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          we,
  output logic          chk,
  output logic [DW-1:0] exp_d
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam int PW = (NPASS > 1) ? $clog2(NPASS) : 1;
  localparam logic [AW-1:0] LAST_A = {AW{1'b1}};
  localparam logic [AW-1:0] LAST_L = AW'(AW - 1);
  localparam logic [BW-1:0] LAST_B = BW'(DW - 1);
  localparam logic [PW-1:0] LAST_P = PW'(NPASS - 1);
  localparam logic [DW-1:0] ONES   = {DW{1'b1}};

  phase_t        ph_q, ph_d;
  logic [AW-1:0] a_q, a_d;
  logic [BW-1:0] b_q, b_d;
  logic [1:0]    s_q, s_d;
  logic [PW-1:0] p_q, p_d;
  logic          step_en;
  logic [DW-1:0] self_d;
  logic [DW-1:0] walk_d;

  generate
    if (DW > AW) begin : g_zext
      assign self_d = {{(DW-AW){1'b0}}, a_q};
    end else if (DW == AW) begin : g_same
      assign self_d = a_q;
    end else begin : g_trunc
      assign self_d = a_q[DW-1:0];
    end
  endgenerate

  assign walk_d    = ONES ^ (DW'(1) << b_q);
  assign busy      = (ph_q != PH_IDLE) && (ph_q != PH_DONE);
  assign start_acc = start && !busy;
  assign step_en   = busy || start_acc;
  assign phase     = ph_q;

  // memory port decode
  always_comb begin
    addr  = a_q;
    wdata = ONES;
    we    = 1'b0;
    chk   = 1'b0;
    exp_d = ONES;
    unique case (ph_q)
      PH_FILL_A, PH_FILL_D: we = 1'b1;
      PH_ABASE: begin
        addr  = '0;
        wdata = '0;
        we    = 1'b1;
      end
      PH_APROBE: begin
        addr = AW'(1) << a_q;
        chk  = 1'b1;
      end
      PH_DWALK: begin
        if (s_q == 2'd0) begin
          we    = 1'b1;
          wdata = walk_d;
        end else if (s_q == 2'd1) begin
          chk   = 1'b1;
          exp_d = walk_d;
        end else begin
          we    = 1'b1;
        end
      end
      PH_SWR: begin
        we    = 1'b1;
        wdata = self_d;
      end
      PH_SRD: begin
        chk   = 1'b1;
        exp_d = self_d;
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    ph_d = ph_q;
    a_d  = a_q + 1'b1;
    b_d  = b_q;
    s_d  = s_q;
    p_d  = p_q;
    unique case (ph_q)
      PH_IDLE, PH_DONE: begin
        a_d = '0;
        if (start) begin
          ph_d = PH_FILL_A;
          b_d  = '0;
          s_d  = '0;
          p_d  = '0;
        end
      end
      PH_FILL_A: if (a_q == LAST_A) ph_d = PH_ABASE;
      PH_ABASE: begin
        a_d  = '0;
        ph_d = PH_APROBE;
      end
      PH_APROBE: if (a_q == LAST_L) begin
        a_d  = '0;
        ph_d = PH_FILL_D;
      end
      PH_FILL_D: if (a_q == LAST_A) ph_d = PH_DWALK;
      PH_DWALK: begin
        a_d = a_q;
        if (s_q == 2'd2) begin
          s_d = '0;
          if (b_q == LAST_B) begin
            b_d = '0;
            a_d = a_q + 1'b1;
            if (a_q == LAST_A) ph_d = PH_SWR;
          end else begin
            b_d = b_q + 1'b1;
          end
        end else begin
          s_d = s_q + 1'b1;
        end
      end
      PH_SWR: if (a_q == LAST_A) ph_d = PH_SRD;
      PH_SRD: if (a_q == LAST_A) begin
        if (p_q == LAST_P) ph_d = PH_DRAIN;
        else begin
          ph_d = PH_SWR;
          p_d  = p_q + 1'b1;
        end
      end
      PH_DRAIN: ph_d = PH_DONE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      a_q  <= '0;
      b_q  <= '0;
      s_q  <= '0;
      p_q  <= '0;
    end else if (step_en) begin
      ph_q <= ph_d;
      a_q  <= a_d;
      b_q  <= b_d;
      s_q  <= s_d;
      p_q  <= p_d;
    end
  end
endmodule

// File: rtl/lpb_cmp.sv
module lpb_cmp #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          chk,
  input  logic [DW-1:0] exp_d,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] rdata,
  output logic          fail_flag,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_got
);
  logic          chk_q;
  logic [DW-1:0] exp_q;
  logic [AW-1:0] addr_q;
  logic          miss;
  logic          cap_en;

  assign miss   = chk_q && (rdata != exp_q);
  assign cap_en = miss && !fail_flag;

  // align expectation with the one-cycle read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q  <= 1'b0;
      exp_q  <= '0;
      addr_q <= '0;
    end else begin
      chk_q <= chk;
      if (chk) begin
        exp_q  <= exp_d;
        addr_q <= addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_flag <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_got  <= '0;
    end else if (clr) begin
      fail_flag <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_got  <= '0;
    end else if (cap_en) begin
      fail_flag <= 1'b1;
      fail_addr <= addr_q;
      fail_exp  <= exp_q;
      fail_got  <= rdata;
    end
  end
endmodule

// File: rtl/lpb_top.sv
module lpb_top
  import lpb_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int NPASS = 2
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          start,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_got
);
  logic [1:0]    rsync_q;
  logic          rst_n;
  phase_t        phase;
  logic          busy;
  logic          start_acc;
  logic          chk;
  logic [DW-1:0] exp_d;
  logic          fail_flag;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  lpb_seq #(.AW(AW), .DW(DW), .NPASS(NPASS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .phase     (phase),
    .busy      (busy),
    .start_acc (start_acc),
    .addr      (mem_addr),
    .wdata     (mem_wdata),
    .we        (mem_we),
    .chk       (chk),
    .exp_d     (exp_d)
  );

  lpb_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start_acc),
    .chk       (chk),
    .exp_d     (exp_d),
    .addr      (mem_addr),
    .rdata     (mem_rdata),
    .fail_flag (fail_flag),
    .fail_addr (fail_addr),
    .fail_exp  (fail_exp),
    .fail_got  (fail_got)
  );

  assign done = (phase == PH_DONE);
  assign pass = done && !fail_flag;
endmodule

// File: rtl/lpb_chk.sv
module lpb_chk #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          pass,
  input logic          mem_we,
  input logic          busy,
  input logic          fail_flag,
  input logic [AW-1:0] fail_addr,
  input logic [DW-1:0] fail_got
);
  p_pass_only_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);

  p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  p_fail_kills_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag |-> !pass);

  p_capture_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag && !start |=> fail_flag && $stable(fail_addr) && $stable(fail_got));

  p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);
endmodule

bind lpb_top lpb_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .pass      (pass),
  .mem_we    (mem_we),
  .busy      (busy),
  .fail_flag (fail_flag),
  .fail_addr (fail_addr),
  .fail_got  (fail_got)
);

// File: tb/sim_lpb_top.sv
module sim_lpb_top;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int NPASS = 2;
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  logic          clk;
  logic          rst_ni;
  logic          start;
  logic          done;
  logic          pass;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_exp;
  logic [DW-1:0] fail_got;

  int checks = 0;
  int errors = 0;

  // fault model: 0 none, 1 address line stuck 0, 2 data bit stuck 1, 3 cell bit stuck 0
  int fk = 0;
  int fk_line = 0;
  int fk_bit = 0;
  int fk_cell = 0;
  logic [DW-1:0] mem [DEPTH];

  lpb_top #(.AW(AW), .DW(DW), .NPASS(NPASS)) u0 (
    .clk(clk), .rst_ni(rst_ni), .start(start), .done(done), .pass(pass),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .fail_addr(fail_addr), .fail_exp(fail_exp),
    .fail_got(fail_got)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int phys(input logic [AW-1:0] a);
    if (fk == 1) return int'(a) & ~(1 << fk_line);
    return int'(a);
  endfunction

  function automatic logic [DW-1:0] rd_fault(input int pa, input logic [DW-1:0] v);
    if (fk == 2) return v | (DW'(1) << fk_bit);
    if (fk == 3 && pa == fk_cell) return v & ~(DW'(1) << fk_bit);
    return v;
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[phys(mem_addr)] <= mem_wdata;
    mem_rdata <= rd_fault(phys(mem_addr), mem[phys(mem_addr)]);
  end

  function automatic int exp_cycles();
    return DEPTH * (3 * DW + 2 + 2 * NPASS) + AW + 2;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, expv);
    end
  endtask

  // run one test; poke>0 drives start high for one cycle that many cycles in
  task automatic run(input int poke, output int cyc);
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = (cyc == poke);
      if (cyc > 4 * exp_cycles()) begin
        errors++;
        checks++;
        $display("FAIL watchdog R6 got=%0d expected=%0d", cyc, exp_cycles());
        break;
      end
    end
    start = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL global watchdog R6 got=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    int bad;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    rst_ni = 1'b0;
    start  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 done", done, 0);
    check("R1 pass", pass, 0);
    check("R1 mem_we", mem_we, 0);
    check("R1 fail_addr", fail_addr, 0);
    check("R1 fail_got", fail_got, 0);

    // clean run with a mid-run start poke: R6, R7, R4
    fk = 0;
    run(37, cyc);
    check("R6 cycles clean", cyc, exp_cycles());
    check("R7 pass clean", pass, 1);
    check("R7 done", done, 1);
    bad = 0;
    for (int i = 0; i < DEPTH; i++)
      if (mem[i] !== DW'(i)) bad++;
    check("R4 self-address contents", bad, 0);
    repeat (5) @(negedge clk);
    check("R7 done held", done, 1);
    check("R1 no write when finished", mem_we, 0);

    // random address-line stuck faults: R2
    for (int t = 0; t < 3; t++) begin
      fk = 1;
      fk_line = $urandom % AW;
      run(0, cyc);
      check("R2 pass low", pass, 0);
      check("R2 fail_addr", fail_addr, 1 << fk_line);
      check("R2 fail_exp", fail_exp, ONES);
      check("R2 fail_got", fail_got, 0);
      check("R5 completes R6 cycles", cyc, exp_cycles());
    end

    // random data bit stuck at one: R3, R5 (later misses must not overwrite)
    for (int t = 0; t < 3; t++) begin
      fk = 2;
      fk_bit = $urandom % DW;
      run(0, cyc);
      check("R3 pass low", pass, 0);
      check("R5 fail_addr first", fail_addr, 0);
      check("R3 fail_exp", fail_exp, ONES ^ (DW'(1) << fk_bit));
      check("R3 fail_got", fail_got, ONES);
    end

    // random single cell bit stuck at zero away from probe addresses: R3
    for (int t = 0; t < 3; t++) begin
      int b;
      fk = 3;
      fk_bit = $urandom % DW;
      do fk_cell = $urandom % DEPTH;
      while (fk_cell == 0 || (fk_cell & (fk_cell - 1)) == 0);
      b = (fk_bit == 0) ? 1 : 0;
      run(0, cyc);
      check("R3 cell fail_addr", fail_addr, fk_cell);
      check("R3 cell fail_exp", fail_exp, ONES ^ (DW'(1) << b));
      check("R3 cell fail_got", fail_got, (ONES ^ (DW'(1) << b)) & ~(DW'(1) << fk_bit));
    end

    // restart after a failing run clears the record: R8
    fk = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R8 pass cleared", pass, 0);
    check("R8 fail_addr cleared", fail_addr, 0);
    check("R8 fail_exp cleared", fail_exp, 0);
    while (!done) @(negedge clk);
    check("R8 pass after clean rerun", pass, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule